// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers level-sensitive interrupt requests from a set of peripheral lines and from eight software-controlled flags. Each source has its own 4-bit priority, an enable bit and a mask bit. The block picks the highest-priority pending source and sends one request line to the processor, but only when that priority is strictly above the current-priority register. The path from a source to the request line has a fixed pipeline latency.

When the processor acknowledges the request, the block latches the winning source number as a vector index. It loads the current-priority register with the priority of that source and saves the old value on a small LIFO stack. An end-of-interrupt write pops the saved value back into the current-priority register.

A single-cycle write strobe with an address programs the block. A combinational read port returns the per-source settings, the software flags and the current priority.

Top module: `irq_prio_ctrl`

Address map: `0x00+s` is the settings of source `s`, with data bits [3:0] priority, [4] enable and [5] mask. `0x40+k` is software source `k`, with data bit [0] SET and bit [1] CLR. `0x80` writes the current priority in bits [3:0]. A write of any data to `0x81` is an end-of-interrupt. Peripheral line `p` is source `p`. Software source `k` is source `N_PERIPH+k`.

## Requirements
- R1: After synchronous reset, `irq_req` is 0, `cur_prio` is 0, `irq_vec` is 0, `stk_err` is 0, every software flag reads 0, and every priority, enable and mask is 0.
- R2: A peripheral line that rises between two clock edges, and whose source is enabled, unmasked and above the current priority, drives `irq_req` high after exactly the third following rising edge, and not before.
- R3: A pending source raises `irq_req` only if its priority is strictly greater than `cur_prio`. Equal or lower priority gives no request.
- R4: A source whose priority is 0 never raises `irq_req`, whatever `cur_prio` holds.
- R5: Among pending, enabled and unmasked sources, the highest priority wins. On equal priority, the lowest source number wins. The vector index is the source number.
- R6: Writing 1 to SET (bit 0 at `0x40+k`) sets flag `k`. Writing 0 there does nothing. Bit 0 always reads back 0, and bit 1 reads back the flag. `irq_req` follows a SET write after the third edge following the write edge. Software sources arbitrate exactly like peripheral ones.
- R7: Writing 1 to CLR (bit 1) clears the flag, and writing 0 there does nothing. If SET and CLR are both 1 in the same write, the flag ends up set.
- R8: A disabled or masked source makes no request. Re-enabling or unmasking a source whose flag or line is still active makes the request come back.
- R9: An acknowledge while `irq_req` is high latches the winner's index into `irq_vec` and loads `cur_prio` with that source's currently programmed priority. `irq_req` is low after that edge, and `irq_vec` holds until the next acknowledge.
- R10: Each acknowledge pushes the previous `cur_prio` onto an 8-deep stack. Each end-of-interrupt write restores values in last-in, first-out order.
- R11: A push onto a full stack, or an end-of-interrupt on an empty stack, sets `stk_err`, which stays set until reset. An overflowing acknowledge still loads `cur_prio` and discards the value it could not save.
- R12: An acknowledge and an end-of-interrupt in the same cycle leave the stack depth unchanged and load `cur_prio` with the acknowledged priority. On an empty stack, the same case flags an underflow and saves the old `cur_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_irq | input | N_PERIPH | Level requests from peripherals |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 6 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 6 | Combinational read data |
| ack | input | 1 | Processor acknowledge |
| irq_req | output | 1 | Request to processor |
| irq_vec | output | SRC_W | Latched vector index of the last acknowledged source |
| cur_prio | output | 4 | Current-priority register |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The two functions that can land on the same edge are the acknowledge and the end-of-interrupt pop. The bench provokes this by raising `ack` while an end-of-interrupt write is on the port, once with one saved level and once on an empty stack. It then judges the outcome by the new `cur_prio` and by the number of further end-of-interrupt writes that can run before an underflow appears. A second collision occurs when a software SET and CLR arrive in one write. It is swept for both prior flag states and judged by readback.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int PRIO_W = 4;
    localparam int N_SW   = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 6;

    localparam logic [ADDR_W-1:0] SW_BASE  = 8'h40;
    localparam logic [ADDR_W-1:0] CUR_ADDR = 8'h80;
    localparam logic [ADDR_W-1:0] EOI_ADDR = 8'h81;

    typedef logic [PRIO_W-1:0] prio_t;

    // per-source settings, laid out as the write data word
    typedef struct packed {
        logic  mask;
        logic  en;
        prio_t prio;
    } src_cfg_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CFG,
        OP_SW,
        OP_CUR,
        OP_EOI
    } reg_op_e;

    function automatic reg_op_e decode_addr(input logic [ADDR_W-1:0] a, input int n_src);
        if (int'(a) < n_src)               return OP_CFG;
        if (a[ADDR_W-1:3] == SW_BASE[ADDR_W-1:3]) return OP_SW;
        if (a == CUR_ADDR)                 return OP_CUR;
        if (a == EOI_ADDR)                 return OP_EOI;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_prio_pkg::*;
#(
    parameter int N_PERIPH = 8,
    localparam int N_SRC   = N_PERIPH + N_SW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PERIPH-1:0]       periph_irq,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output src_cfg_t [N_SRC-1:0]      cfg_q,
    output logic [N_SW-1:0]           sw_flag_q,
    output logic [N_SRC-1:0]          pend_q
);

    reg_op_e wr_op;
    assign wr_op = decode_addr(wr_addr, N_SRC);

    for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wr_en && wr_op == OP_CFG && wr_addr == ADDR_W'(i)) begin
                cfg_q[i] <= src_cfg_t'(wr_data);
            end
        end
    end

    // software flags: SET has priority over CLR
    for (genvar k = 0; k < N_SW; k++) begin : g_sw
        logic hit;
        assign hit = wr_en && wr_op == OP_SW && wr_addr[2:0] == 3'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                sw_flag_q[k] <= 1'b0;
            end else if (hit && wr_data[0]) begin
                sw_flag_q[k] <= 1'b1;
            end else if (hit && wr_data[1]) begin
                sw_flag_q[k] <= 1'b0;
            end
        end
    end

    // first pipeline stage: gated request sample
    for (genvar i = 0; i < N_SRC; i++) begin : g_pend
        logic raw;
        if (i < N_PERIPH) begin : g_p
            assign raw = periph_irq[i];
        end else begin : g_s
            assign raw = sw_flag_q[i-N_PERIPH];
        end
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= raw && cfg_q[i].en && !cfg_q[i].mask;
        end
    end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int N_SRC  = 16,
    localparam int SRC_W = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SRC-1:0]     pend,
    input  src_cfg_t [N_SRC-1:0] cfg,
    output logic                 win_valid_q,
    output prio_t                win_prio_q,
    output logic [SRC_W-1:0]     win_idx_q
);

    logic             best_valid;
    prio_t            best_prio;
    logic [SRC_W-1:0] best_idx;

    // scan downward with >= so the lowest index wins a tie
    always_comb begin
        best_valid = 1'b0;
        best_prio  = '0;
        best_idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i] && cfg[i].prio != '0 && cfg[i].prio >= best_prio) begin
                best_valid = 1'b1;
                best_prio  = cfg[i].prio;
                best_idx   = SRC_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid_q <= 1'b0;
            win_prio_q  <= '0;
            win_idx_q   <= '0;
        end else begin
            win_valid_q <= best_valid;
            win_prio_q  <= best_prio;
            win_idx_q   <= best_idx;
        end
    end

endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH   = 8,
    localparam int PTR_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  prio_t push_val,
    input  logic  pop,
    output logic  pop_ok,
    output prio_t pop_val,
    output logic  err_q
);

    prio_t            mem_q [DEPTH];
    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_m1;
    logic             full;

    assign sp_m1   = sp_q - PTR_W'(1);
    assign full    = sp_q == PTR_W'(DEPTH);
    assign pop_ok  = pop && sp_q != '0;
    assign pop_val = pop_ok ? mem_q[sp_m1[IDX_W-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (pop && !pop_ok) err_q <= 1'b1;
            if (push && pop_ok) begin
                // restore and re-save the same level: depth unchanged
                sp_q <= sp_q;
            end else if (pop_ok) begin
                sp_q <= sp_m1;
            end else if (push) begin
                if (full) begin
                    err_q <= 1'b1;
                end else begin
                    mem_q[sp_q[IDX_W-1:0]] <= push_val;
                    sp_q <= sp_q + PTR_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int N_PERIPH    = 8,
    parameter int STACK_DEPTH = 8,
    localparam int N_SRC      = N_PERIPH + N_SW,
    localparam int SRC_W      = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_PERIPH-1:0] periph_irq,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                ack,
    output logic                irq_req,
    output logic [SRC_W-1:0]    irq_vec,
    output logic [PRIO_W-1:0]   cur_prio,
    output logic                stk_err
);

    src_cfg_t [N_SRC-1:0] cfg_q;
    logic [N_SW-1:0]      sw_flag_q;
    logic [N_SRC-1:0]     pend_q;
    logic                 win_valid_q;
    prio_t                win_prio_q;
    logic [SRC_W-1:0]     win_idx_q;

    logic                 req_q;
    prio_t                req_prio_q;
    logic [SRC_W-1:0]     req_idx_q;
    logic [SRC_W-1:0]     vec_q;
    prio_t                cur_q;

    logic                 ack_take;
    logic                 eoi_wr;
    logic                 pop_ok;
    prio_t                pop_val;
    reg_op_e              wr_op;
    reg_op_e              rd_op;

    irq_src_regs #(.N_PERIPH(N_PERIPH)) u_regs (
        .clk(clk), .rst(rst), .periph_irq(periph_irq),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_q(cfg_q), .sw_flag_q(sw_flag_q), .pend_q(pend_q)
    );

    irq_prio_arb #(.N_SRC(N_SRC)) u_arb (
        .clk(clk), .rst(rst), .pend(pend_q), .cfg(cfg_q),
        .win_valid_q(win_valid_q), .win_prio_q(win_prio_q), .win_idx_q(win_idx_q)
    );

    assign wr_op    = decode_addr(wr_addr, N_SRC);
    assign rd_op    = decode_addr(rd_addr, N_SRC);
    assign ack_take = ack && req_q;
    assign eoi_wr   = wr_en && wr_op == OP_EOI;

    irq_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst(rst), .push(ack_take), .push_val(cur_q),
        .pop(eoi_wr), .pop_ok(pop_ok), .pop_val(pop_val), .err_q(stk_err)
    );

    // third pipeline stage: threshold compare; acknowledge consumes it
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            req_prio_q <= '0;
            req_idx_q  <= '0;
        end else begin
            req_q      <= !ack_take && win_valid_q && win_prio_q > cur_q;
            req_prio_q <= win_prio_q;
            req_idx_q  <= win_idx_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            vec_q <= '0;
        end else begin
            if (ack_take) begin
                cur_q <= req_prio_q;
                vec_q <= req_idx_q;
            end else if (pop_ok) begin
                cur_q <= pop_val;
            end else if (wr_en && wr_op == OP_CUR) begin
                cur_q <= wr_data[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        case (rd_op)
            OP_CFG:  rd_data = cfg_q[rd_addr[SRC_W-1:0]];
            OP_SW:   rd_data = {4'b0, sw_flag_q[rd_addr[2:0]], 1'b0};
            OP_CUR:  rd_data = {2'b0, cur_q};
            default: rd_data = '0;
        endcase
    end

    assign irq_req  = req_q;
    assign irq_vec  = vec_q;
    assign cur_prio = cur_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int VEC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [3:0]       cur_prio,
    input logic             stk_err
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_req && cur_prio == 4'd0 && !stk_err)); // R1

    AST_ACK_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req) |=> !irq_req); // R9

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        !(ack && irq_req) |=> $stable(irq_vec)); // R9

    AST_ACK_RAISES_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req) |=> cur_prio > $past(cur_prio)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err); // R11

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(SRC_W)) i_chk (
    .clk(clk), .rst(rst), .ack(ack), .irq_req(irq_req),
    .irq_vec(irq_vec), .cur_prio(cur_prio), .stk_err(stk_err)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    localparam int NP = 8;
    localparam int NS = NP + 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] periph_irq = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [5:0]    wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [5:0]    rd_data;
    logic          ack = 1'b0;
    logic          irq_req;
    logic [3:0]    irq_vec;
    logic [3:0]    cur_prio;
    logic          stk_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    irq_prio_ctrl #(.N_PERIPH(NP), .STACK_DEPTH(8)) i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .periph_irq(periph_irq),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .cur_prio(cur_prio), .stk_err(stk_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [5:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int s, input int p, input bit en, input bit mk);
        wr(8'(s), {mk, en, 4'(p)});
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic activate(input int s);
        if (s < NP) periph_irq[s] = 1'b1;
        else        wr(8'h40 + 8'(s - NP), 6'h01);
    endtask

    task automatic deactivate(input int s);
        if (s < NP) periph_irq[s] = 1'b0;
        else        wr(8'h40 + 8'(s - NP), 6'h02);
    endtask

    task automatic do_reset();
        rst = 1'b1; periph_irq = '0; ack = 1'b0; wr_en = 1'b0;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq_req", int'(irq_req), 0);
        chk("R1 cur_prio", int'(cur_prio), 0);
        chk("R1 irq_vec", int'(irq_vec), 0);
        chk("R1 stk_err", int'(stk_err), 0);
        rd_addr = 8'h43; #1;
        chk("R1 sw flag", int'(rd_data), 0);
        rd_addr = 8'h05; #1;
        chk("R1 src cfg", int'(rd_data), 0);

        // R2 peripheral latency
        cfg(3, 7, 1, 0);
        tick(1);
        periph_irq[3] = 1'b1;
        tick(2);
        chk("R2 early", int'(irq_req), 0);
        tick(1);
        chk("R2 third edge", int'(irq_req), 1);

        // R8 enable and mask gating
        cfg(3, 7, 0, 0); tick(4);
        chk("R8 disabled", int'(irq_req), 0);
        cfg(3, 7, 1, 1); tick(4);
        chk("R8 masked", int'(irq_req), 0);
        cfg(3, 7, 1, 0); tick(4);
        chk("R8 reenabled", int'(irq_req), 1);

        // R9 drop, reprogram, reassert: ack uses the new priority
        periph_irq[3] = 1'b0; tick(4);
        chk("R9 dropped", int'(irq_req), 0);
        cfg(3, 9, 1, 0);
        periph_irq[3] = 1'b1; tick(4);
        do_ack();
        chk("R9 req low after ack", int'(irq_req), 0);
        chk("R9 vec", int'(irq_vec), 3);
        chk("R9 cur", int'(cur_prio), 9);
        periph_irq[3] = 1'b0;
        cfg(12, 14, 1, 0); activate(12); tick(6);
        chk("R9 vec held", int'(irq_vec), 3);
        do_reset();

        // R6 software flag latency
        cfg(NP + 2, 5, 1, 0);
        wr(8'h42, 6'h01);
        tick(2);
        chk("R6 sw early", int'(irq_req), 0);
        tick(1);
        chk("R6 sw third edge", int'(irq_req), 1);
        do_reset();

        // R6 / R7 set/clear sweep (sources disabled)
        for (int k = 0; k < 8; k++) begin
            for (int prev = 0; prev < 2; prev++) begin
                for (int d = 0; d < 4; d++) begin
                    int expf;
                    wr(8'h40 + 8'(k), prev != 0 ? 6'h01 : 6'h02);
                    wr(8'h40 + 8'(k), 6'(d));
                    rd_addr = 8'h40 + 8'(k); #1;
                    expf = (d & 1) != 0 ? 1 : ((d & 2) != 0 ? 0 : prev);
                    chk((d & 1) != 0 ? "R6 flag" : "R7 flag", int'(rd_data[1]), expf);
                    chk("R6 set reads zero", int'(rd_data[0]), 0);
                end
            end
        end
        do_reset();

        // R3 / R4 threshold sweep on source 0
        periph_irq[0] = 1'b1;
        for (int c = 0; c < 16; c++) begin
            wr(8'h80, 6'(c));
            for (int p = 0; p < 16; p++) begin
                cfg(0, p, 1, 0);
                tick(4);
                chk(p == 0 ? "R4 zero prio" : "R3 compare", int'(irq_req), (p > c) ? 1 : 0);
            end
        end
        do_reset();

        // R5 pairwise arbitration over all sources
        for (int i = 0; i < NS; i++) begin
            for (int j = 0; j < NS; j++) begin
                if (i != j) begin
                    int pa, pb, ew, ep;
                    pa = 1 + ((i * 3 + j) % 4);
                    pb = 1 + ((i + j * 5) % 4);
                    ew = (pa > pb) ? i : (pb > pa) ? j : (i < j ? i : j);
                    ep = (pa > pb) ? pa : pb;
                    cfg(i, pa, 1, 0); cfg(j, pb, 1, 0);
                    activate(i); activate(j);
                    tick(4);
                    chk("R5 req", int'(irq_req), 1);
                    do_ack();
                    chk("R5 vec", int'(irq_vec), ew);
                    chk("R5 cur", int'(cur_prio), ep);
                    deactivate(i); deactivate(j);
                    cfg(i, 0, 0, 0); cfg(j, 0, 0, 0);
                    tick(4);
                    wr(8'h81, 6'h00);
                    chk("R10 restore", int'(cur_prio), 0);
                end
            end
        end
        chk("R11 no spurious err", int'(stk_err), 0);
        do_reset();

        // R10 / R11 nested acks to overflow, then unwinding
        for (int k = 0; k < 9; k++) begin
            cfg(k, k + 1, 1, 0);
            activate(k);
            tick(4);
            chk("R10 nested req", int'(irq_req), 1);
            do_ack();
            chk("R10 nested cur", int'(cur_prio), k + 1);
            chk("R11 overflow", int'(stk_err), k == 8 ? 1 : 0);
        end
        for (int k = 7; k >= 0; k--) begin
            wr(8'h81, 6'h00);
            chk("R10 lifo pop", int'(cur_prio), k);
        end
        chk("R11 sticky", int'(stk_err), 1);
        do_reset();
        wr(8'h81, 6'h00);
        chk("R11 underflow", int'(stk_err), 1);
        chk("R11 cur kept", int'(cur_prio), 0);
        do_reset();

        // R12 ack and end-of-interrupt on the same edge
        cfg(0, 3, 1, 0); periph_irq[0] = 1'b1; tick(4);
        do_ack();
        chk("R12 first ack", int'(cur_prio), 3);
        cfg(1, 6, 1, 0); periph_irq[1] = 1'b1; tick(4);
        chk("R12 second req", int'(irq_req), 1);
        ack = 1'b1;
        wr(8'h81, 6'h00);
        ack = 1'b0;
        chk("R12 cur", int'(cur_prio), 6);
        chk("R12 vec", int'(irq_vec), 1);
        chk("R12 no err", int'(stk_err), 0);
        periph_irq = '0; cfg(0, 0, 0, 0); cfg(1, 0, 0, 0); tick(4);
        wr(8'h81, 6'h00);
        chk("R12 depth one", int'(cur_prio), 0);
        chk("R12 still no err", int'(stk_err), 0);
        wr(8'h81, 6'h00);
        chk("R12 then empty", int'(stk_err), 1);
        do_reset();

        // R12 on an empty stack: underflow flagged, old level saved
        cfg(2, 4, 1, 0); periph_irq[2] = 1'b1; tick(4);
        ack = 1'b1;
        wr(8'h81, 6'h00);
        ack = 1'b0;
        chk("R12 empty err", int'(stk_err), 1);
        chk("R12 empty cur", int'(cur_prio), 4);
        periph_irq = '0; tick(4);
        wr(8'h81, 6'h00);
        chk("R12 saved level", int'(cur_prio), 0);

        finish_run();
    end

endmodule